// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a two-wire serial memory. It holds a byte array inside the chip and is reached over a pair of open-drain lines: a clock line and a data line. Both lines are oversampled by a much faster system clock. The block finds bus start and stop events on those samples and takes in an eight-bit slave address. It compares that address with a fixed device-type code and three strap inputs. On a match it acknowledges, then serves single-byte writes and sequential reads against the array.

The data line is open-drain. It is therefore split into three signals: the sampled bus level coming in, an enable that pulls the line low, and the level driven while enabled, which is always low. A write-protect input freezes the array but leaves every bus response unchanged.

A parameter widens the array beyond 256 bytes. Each extra address bit takes over one strap position, starting from the lowest. That strap position is then no longer compared, and the matching slave-address bit becomes an upper word-address bit.

Top module: `eep_tw_slave`

## Requirements
- R1: After reset, and in idle before any START, the slave never enables its data-line pull-down, whatever bytes are clocked. A START is a fall of the data line while the clock line is high. A START at any point, including in the middle of a byte, restarts slave-address reception at bit 0.
- R2: A STOP is a rise of the data line while the clock line is high. It returns the slave to idle and releases the data line.
- R3: Bytes travel most significant bit first. The slave samples incoming bits on the clock rising edge and changes its own data-line drive only while the clock line is low.
- R4: Slave address layout: bits 7..4 must equal 1010, bits 3..1 are compared with straps A2, A1, A0, and bit 0 is the direction. On any mismatch the slave gives no acknowledge and ignores the bus until the next START.
- R5: The slave acknowledges a matching slave address, the word-address byte and the data byte by pulling the data line low for the whole ninth clock.
- R6: In a write (direction bit 0), the byte after the slave address is the word address and the next byte is data. The data byte is stored when its acknowledge clock ends. The address pointer then holds word address plus one, so a following read without a word address returns the next location.
- R7: While write protect is high, no array location changes. All acknowledges are still given.
- R8: In a read (direction bit 1), the slave sends the byte at the pointer and then advances the pointer. A master acknowledge (data low on the ninth clock) makes it send the next byte. A master non-acknowledge makes it release the line and wait for STOP.
- R9: A write of only a word address, followed by a repeated START and a read, returns data from that word address.
- R10: With EXT_BITS = n, the lowest n strap positions are not compared. Slave-address bits n..1 become word-address bits 8+n-1..8, so A0 maps to bit 8 first.
- R11: The address pointer wraps from the last location to location 0 during sequential reads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled level of the bus clock line |
| sda_i | input | 1 | Sampled level of the bus data line |
| strap_i | input | 3 | Device strap inputs {A2, A1, A0} |
| wp_i | input | 1 | Write protect; high makes the array read-only |
| sda_oe | output | 1 | High enables the data-line driver |
| sda_lvl | output | 1 | Level driven while enabled (always 0) |

## Verification
The bench builds the block with EXT_BITS = 1 and straps set to 101. Strap A0 is therefore ignored and becomes word-address bit 8. This setting makes two 256-byte blocks reachable: the bench checks that they stay separate, that the pointer wraps from the top of the second block back to location 0, and that a mismatch on A2 is still refused. The 512-byte array stays small enough to elaborate quickly and still reaches a case that the flat default configuration cannot.

// File: rtl/eep_tw_pkg.sv
// Package: shared types and constants for the two-wire memory slave.
// Assumes: nothing; pure declarations.
package eep_tw_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,    // waiting for START
        PH_DEV,     // receiving slave address
        PH_WORD,    // receiving word address
        PH_DATA,    // receiving write data
        PH_READ,    // transmitting read data
        PH_IGNORE   // not addressed / done, wait for START or STOP
    } phase_t;

    localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_tw_linecond.sv
// Module: line conditioner. Synchronises both bus lines through a
// flop chain and derives clock edges plus START/STOP events.
// Assumes: bus lines idle high; system clock well above bus clock.
module eep_tw_linecond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] last;

    assign raw = {sda_i, scl_i};

    genvar g;
    generate
        for (g = 0; g < NLINES; g++) begin : g_line
            logic [SYNC_STAGES-1:0] chain;
            // Purpose: move one line into the system clock domain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[SYNC_STAGES-2:0], raw[g]};
            end
            assign synced[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    // Purpose: keep the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last <= '1;
        else        last <= synced;
    end

    assign sda_s    = synced[1];
    assign scl_rise =  synced[0] & ~last[0];
    assign scl_fall = ~synced[0] &  last[0];
    assign start_ev = synced[0] & last[0] &  last[1] & ~synced[1];
    assign stop_ev  = synced[0] & last[0] & ~last[1] &  synced[1];
endmodule

// File: rtl/eep_tw_array.sv
// Module: byte array with one registered write port and an
// asynchronous read port; a lock input suppresses all writes.
// Assumes: contents are not reset; software-visible state is written first.
module eep_tw_array #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          wr_req,
    input  logic          lock,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    // Purpose: store a byte unless the array is locked.
    always_ff @(posedge clk) begin
        if (wr_req && !lock) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/eep_tw_slave.sv
// Module: two-wire serial memory slave top. Decodes the slave address,
// acknowledges, and serves single-byte writes and sequential reads.
// Assumes: the bus master follows the two-wire protocol; no clock
// stretching; EXT_BITS in 0..3 picks how many strap bits become
// upper word-address bits.
module eep_tw_slave
    import eep_tw_pkg::*;
#(
    parameter int EXT_BITS    = 0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    input  logic       wp_i,
    output logic       sda_oe,
    output logic       sda_lvl
);
    localparam int         AW       = 8 + EXT_BITS;
    localparam logic [2:0] CMP_MASK = 3'b111 << EXT_BITS;

    logic          sda_s, scl_rise, scl_fall, start_ev, stop_ev;
    phase_t        phase;
    logic [3:0]    bitcnt;
    logic [7:0]    shreg;
    logic [7:0]    txsh;
    logic          in_ack;
    logic          rd_q;
    logic          mack;
    logic          oe_q;
    logic [AW-1:0] ptr;
    logic [AW-1:0] waddr_q;
    logic [7:0]    wdata_q;
    logic          wr_req;
    logic [7:0]    rdata;
    logic          dev_hit;
    logic          dev_cap;
    logic [AW-1:0] dev_ptr;
    logic [AW-1:0] word_ptr;

    eep_tw_linecond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    eep_tw_array #(.AW(AW)) u_mem (
        .clk    (clk),
        .wr_req (wr_req),
        .lock   (wp_i),
        .waddr  (waddr_q),
        .wdata  (wdata_q),
        .raddr  (ptr),
        .rdata  (rdata)
    );

    assign dev_hit = (shreg[7:4] == DEV_CODE) &&
                     (((shreg[3:1] ^ strap_i) & CMP_MASK) == 3'b000);

    // Slave-address acknowledge decision cycle (block bits captured here).
    assign dev_cap = scl_fall && !start_ev && !stop_ev && (phase == PH_DEV) &&
                     (bitcnt == 4'd8) && !in_ack && dev_hit;

    generate
        if (EXT_BITS == 0) begin : g_flat
            assign dev_ptr  = ptr;
            assign word_ptr = shreg;
        end else begin : g_blk
            logic [EXT_BITS-1:0] blk_q;
            // Purpose: remember the block-select bits of the slave address.
            always_ff @(posedge clk) begin
                if (!rst_n)       blk_q <= '0;
                else if (dev_cap) blk_q <= shreg[EXT_BITS:1];
            end
            assign dev_ptr  = {shreg[EXT_BITS:1], ptr[7:0]};
            assign word_ptr = {blk_q, shreg};
        end
    endgenerate

    // Purpose: bus protocol sequencer (receive, acknowledge, transmit).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            txsh    <= '0;
            in_ack  <= 1'b0;
            rd_q    <= 1'b0;
            mack    <= 1'b0;
            oe_q    <= 1'b0;
            ptr     <= '0;
            waddr_q <= '0;
            wdata_q <= '0;
            wr_req  <= 1'b0;
        end else begin
            wr_req <= 1'b0;
            if (stop_ev) begin
                phase  <= PH_IDLE;
                bitcnt <= '0;
                in_ack <= 1'b0;
                oe_q   <= 1'b0;
            end else if (start_ev) begin
                phase  <= PH_DEV;
                bitcnt <= '0;
                in_ack <= 1'b0;
                oe_q   <= 1'b0;
            end else begin
                case (phase)
                    PH_DEV, PH_WORD, PH_DATA: begin
                        if (scl_rise && bitcnt < 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            if (!in_ack) begin
                                if (phase == PH_DEV && !dev_hit) begin
                                    phase <= PH_IGNORE;
                                end else begin
                                    in_ack <= 1'b1;
                                    oe_q   <= 1'b1;
                                    if (phase == PH_DEV) begin
                                        rd_q <= shreg[0];
                                        if (shreg[0]) ptr <= dev_ptr;
                                    end
                                    if (phase == PH_WORD) ptr <= word_ptr;
                                end
                            end else begin
                                in_ack <= 1'b0;
                                bitcnt <= '0;
                                oe_q   <= 1'b0;
                                if (phase == PH_DEV) begin
                                    if (rd_q) begin
                                        phase <= PH_READ;
                                        txsh  <= rdata;
                                        oe_q  <= ~rdata[7];
                                        ptr   <= ptr + 1'b1;
                                    end else begin
                                        phase <= PH_WORD;
                                    end
                                end else if (phase == PH_WORD) begin
                                    phase <= PH_DATA;
                                end else begin
                                    wr_req  <= 1'b1;
                                    waddr_q <= ptr;
                                    wdata_q <= shreg;
                                    ptr     <= ptr + 1'b1;
                                    phase   <= PH_IGNORE;
                                end
                            end
                        end
                    end
                    PH_READ: begin
                        if (scl_rise) begin
                            if (bitcnt == 4'd8) mack <= ~sda_s;
                            if (bitcnt < 4'd9)  bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bitcnt < 4'd8) begin
                                txsh <= {txsh[6:0], 1'b0};
                                oe_q <= ~txsh[6];
                            end else if (bitcnt == 4'd8) begin
                                oe_q <= 1'b0;
                            end else if (mack) begin
                                txsh   <= rdata;
                                oe_q   <= ~rdata[7];
                                ptr    <= ptr + 1'b1;
                                bitcnt <= '0;
                            end else begin
                                phase <= PH_IGNORE;
                                oe_q  <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe  = oe_q;
    assign sda_lvl = 1'b0;
endmodule

// File: rtl/eep_tw_chk.sv
// Module: protocol checker bound to the slave top.
// Assumes: the bus master never raises SCL within a few system clocks
// of lowering it.
module eep_tw_chk
    import eep_tw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       start_ev,
    input logic       stop_ev,
    input phase_t     phase,
    input logic [3:0] bitcnt
);
    p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_oe) && !$past(start_ev) && !$past(stop_ev)) |-> !scl_i);

    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (phase == PH_IDLE) && !sda_oe);

    p_start_dev_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && !stop_ev) |=> (phase == PH_DEV) && (bitcnt == 4'd0) && !sda_oe);

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> !sda_oe);

    p_ignore_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IGNORE) |-> !sda_oe);

    p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd9);
endmodule

bind eep_tw_slave eep_tw_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_oe   (sda_oe),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .phase    (phase),
    .bitcnt   (bitcnt)
);

// File: tb/sim_eep_tw_slave.sv
module sim_eep_tw_slave;
    localparam int         Q     = 8;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic sda_oe, sda_lvl, sda_bus;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    assign sda_bus = sda_m && !(sda_oe && !sda_lvl);

    eep_tw_slave #(.EXT_BITS(1)) u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_bus),
        .strap_i (STRAP),
        .wp_i    (wp),
        .sda_oe  (sda_oe),
        .sda_lvl (sda_lvl)
    );

    // Scoreboard
    typedef struct { string tag; int exp; } item_t;
    item_t sb_q[$];
    event  obs_ev;
    int    obs_val;

    task automatic expect_val(string tag, int v);
        item_t it;
        it.tag = tag;
        it.exp = v;
        sb_q.push_back(it);
    endtask

    task automatic observe(int v);
        obs_val = v;
        ->obs_ev;
        #1;
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(obs_ev);
            total++;
            if (sb_q.size() == 0) begin
                bad++;
                $display("FAIL unexpected observation got=%0h exp=none", obs_val);
            end else begin
                it = sb_q.pop_front();
                if (obs_val !== it.exp) begin
                    bad++;
                    $display("FAIL %s got=%0h exp=%0h", it.tag, obs_val, it.exp);
                end
            end
        end
    end

    // Bus master primitives
    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        scl_m = 0; wclk(Q); sda_m = 1; wclk(Q);
        scl_m = 1; wclk(Q); sda_m = 0; wclk(Q);
        scl_m = 0; wclk(Q);
    endtask

    task automatic bus_stop();
        scl_m = 0; wclk(Q); sda_m = 0; wclk(Q);
        scl_m = 1; wclk(Q); sda_m = 1; wclk(Q);
    endtask

    task automatic put_bit(bit b);
        sda_m = b; wclk(Q);
        scl_m = 1; wclk(2 * Q);
        scl_m = 0; wclk(Q);
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1; wclk(Q);
        scl_m = 1; wclk(Q);
        b = sda_bus; wclk(Q);
        scl_m = 0; wclk(Q);
    endtask

    task automatic send_byte(logic [7:0] v, string tag, bit exp_ack);
        bit b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        expect_val(tag, exp_ack);
        observe(!b);
    endtask

    task automatic recv_byte(bit m_ack, string tag, logic [7:0] exp);
        logic [7:0] v;
        bit b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
        put_bit(!m_ack);
        expect_val(tag, exp);
        observe(v);
    endtask

    function automatic logic [7:0] dev(bit blk, bit rd);
        return {4'b1010, STRAP[2], STRAP[1], blk, rd};
    endfunction

    task automatic wr(bit blk, logic [7:0] a, logic [7:0] d);
        bus_start();
        send_byte(dev(blk, 0), "R5 slave address ack", 1);
        send_byte(a, "R5 word address ack", 1);
        send_byte(d, "R5 data ack", 1);
        bus_stop();
    endtask

    task automatic rd_random(bit blk, logic [7:0] a, int n,
                             logic [7:0] e0, logic [7:0] e1, string tag);
        bus_start();
        send_byte(dev(blk, 0), "R9 setup ack", 1);
        send_byte(a, "R9 word ack", 1);
        bus_start();
        send_byte(dev(blk, 1), "R8 read address ack", 1);
        recv_byte(n > 1, tag, e0);
        if (n > 1) recv_byte(0, tag, e1);
        wclk(Q);
        expect_val("R8 released after nack", 0);
        observe(sda_oe);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=timeout exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : driver
        wclk(4);
        rst_n = 1;
        wclk(4);
        expect_val("R1 reset drive", 0);
        observe(sda_oe);

        // R1: bytes clocked with no START are ignored
        scl_m = 0; wclk(Q);
        send_byte(dev(0, 0), "R1 no ack without START", 0);
        bus_stop();

        wr(0, 8'h10, 8'h3C);
        wr(0, 8'h11, 8'h5E);
        wr(1, 8'h11, 8'hA5);
        wr(0, 8'h21, 8'h88);
        wr(0, 8'h20, 8'h77);

        // R6: current-address read follows the last write
        bus_start();
        send_byte(dev(0, 1), "R6 read ack", 1);
        recv_byte(0, "R6 pointer after write", 8'h88);
        bus_stop();

        // R8, R9, R3: random read with continuation
        rd_random(0, 8'h10, 2, 8'h3C, 8'h5E, "R3 R8 R9 random sequential read");
        // R10: block bit selects the upper half
        rd_random(1, 8'h11, 1, 8'hA5, 8'h00, "R10 block-select read");

        // R11: wrap from last location to 0
        wr(1, 8'hFF, 8'h42);
        wr(0, 8'h00, 8'h24);
        rd_random(1, 8'hFF, 2, 8'h42, 8'h24, "R11 pointer wrap");

        // R7: write protect
        wp = 1;
        wr(0, 8'h10, 8'hFF);
        wp = 0;
        rd_random(0, 8'h10, 1, 8'h3C, 8'h00, "R7 protected location unchanged");

        // R4: strap mismatch on A2, then further byte ignored
        bus_start();
        send_byte({4'b1010, ~STRAP[2], STRAP[1], 1'b0, 1'b0}, "R4 strap mismatch nack", 0);
        send_byte(8'h10, "R4 ignored until START", 0);
        bus_stop();
        // R4: wrong type code
        bus_start();
        send_byte({4'b1011, STRAP[2], STRAP[1], 1'b0, 1'b0}, "R4 type code mismatch nack", 0);
        bus_stop();

        // R1: repeated START mid-byte restarts address reception
        bus_start();
        send_byte(dev(0, 0), "R1 pre-restart ack", 1);
        put_bit(1); put_bit(1); put_bit(1);
        bus_start();
        send_byte(dev(0, 0), "R1 restart address ack", 1);
        send_byte(8'h11, "R1 restart word ack", 1);
        bus_start();
        send_byte(dev(0, 1), "R1 restart read ack", 1);
        recv_byte(0, "R1 read after mid-byte restart", 8'h5E);
        bus_stop();

        // R2: after STOP the slave is idle and silent
        wclk(Q);
        expect_val("R2 idle after STOP", 0);
        observe(sda_oe);

        wclk(Q);
        if (sb_q.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard leftover got=%0d exp=0", sb_q.size());
        end
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule